// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides two integers of a parameterised width W, either as unsigned numbers or as two's-complement signed numbers. It resolves one quotient bit per clock. The partial remainder and the quotient share a single shift register. The divisor register and the subtractor are only as wide as the operands, plus one guard bit on the remainder side.

A start pulse, taken while the block is idle, captures the operands and a mode select. In signed mode the block first turns both operands into magnitudes and records the signs. It then runs one pre-shift cycle, W restoring steps and one finishing cycle. The finishing cycle shifts the remainder half right, applies the signs and registers both results.

The quotient appears on `lo` and the remainder on `hi`. Both stay valid, with `done` held high, until the next accepted start.

Top module: `rdiv_top`

## Requirements
- R1: While the internal reset is active, and after it is released with no start, `busy`, `done`, `hi` and `lo` are all zero.
- R2: In unsigned mode (`signed_mode`=0) with a non-zero divisor, `lo` equals the integer quotient of dividend by divisor, and `hi` equals the remainder, which is less than the divisor.
- R3: With W=4, unsigned, dividing 7 by 2 gives `lo`=3 and `hi`=1.
- R4: In signed mode (`signed_mode`=1, operands read as two's complement), the quotient magnitude is |dividend|/|divisor|. The quotient is negated exactly when the two operand signs differ. The result wraps modulo 2^W and no overflow indication exists.
- R5: In signed mode the remainder magnitude is |dividend| mod |divisor|, and the remainder carries the sign of the dividend.
- R6: A zero divisor completes in the normal cycle count with no trap. The quotient magnitude becomes all ones and the remainder magnitude becomes |dividend|. In unsigned mode this gives `lo` all ones and `hi` equal to the dividend. In signed mode the sign rules of R4 and R5 are then applied.
- R7: A start seen on a rising edge while idle clears `done` and raises `busy` at that edge. `done` rises, and `busy` falls, on the (W+2)-th rising edge after that one. `busy` and `done` are never high together.
- R8: While `done` is high, `hi` and `lo` hold their values regardless of the operand inputs. A start pulse seen while `busy` is high is ignored, so the running division completes with its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begins a division when the block is idle |
| signed_mode | input | 1 | 1 selects two's-complement operands, 0 selects unsigned |
| dividend | input | W | Dividend, sampled with an accepted start |
| divisor | input | W | Divisor, sampled with an accepted start |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | High from completion until the next accepted start |
| hi | output | W | Remainder |
| lo | output | W | Quotient |

## Verification
The hardest case to reach from the ports is a start pulse that arrives in the middle of a running division. An early capture would silently replace the operands, so the bench raises start a few cycles into an operation, with different operands, and checks that the original result still comes out. The signed corners also need deliberate coverage: the most negative dividend, a divisor of minus one, and a zero divisor with a negative dividend. These are covered by running every operand pair at W=4 in both modes and comparing against a magnitude-and-sign model.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_STEP  = 2'd2,
    ST_FIX   = 2'd3
  } rdiv_state_e;
endpackage

// File: rtl/rdiv_magnitude.sv
module rdiv_magnitude #(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  input  logic         use_sign,
  output logic [W-1:0] mag,
  output logic         neg
);
  always_comb begin
    neg = use_sign & val[W-1];
    mag = neg ? (~val + W'(1)) : val;
  end
endmodule

// File: rtl/rdiv_step.sv
module rdiv_step #(
  parameter int W = 32
) (
  input  logic [W:0]   part_in,
  input  logic [W-1:0] dvs,
  output logic [W:0]   part_out,
  output logic         qbit
);
  logic [W:0] diff;

  always_comb begin
    // subtract by adding the two's complement; carry out of the top is dropped
    diff     = part_in + (~{1'b0, dvs} + (W+1)'(1));
    qbit     = ~diff[W];
    part_out = qbit ? diff : part_in;
  end
endmodule

// File: rtl/rdiv_resign.sv
module rdiv_resign #(
  parameter int W = 32
) (
  input  logic [W-1:0] q_mag,
  input  logic [W-1:0] r_mag,
  input  logic         q_neg,
  input  logic         r_neg,
  output logic [W-1:0] q_out,
  output logic [W-1:0] r_out
);
  always_comb begin
    q_out = q_neg ? (~q_mag + W'(1)) : q_mag;
    r_out = r_neg ? (~r_mag + W'(1)) : r_mag;
  end
endmodule

// File: rtl/rdiv_top.sv
module rdiv_top
  import rdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         signed_mode,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int AW = 2*W + 1;
  localparam int CW = $clog2(W + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  // operand magnitudes
  logic [W-1:0] op_val [2];
  logic [W-1:0] op_mag [2];
  logic         op_neg [2];
  assign op_val[0] = dividend;
  assign op_val[1] = divisor;

  for (genvar g = 0; g < 2; g++) begin : g_mag
    rdiv_magnitude #(.W(W)) u_mag (
      .val      (op_val[g]),
      .use_sign (signed_mode),
      .mag      (op_mag[g]),
      .neg      (op_neg[g])
    );
  end

  rdiv_state_e   st_q, st_d;
  logic [AW-1:0] acc_q, acc_d;
  logic [W-1:0]  dvs_q, dvs_d;
  logic          qneg_q, qneg_d, rneg_q, rneg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  hi_q, hi_d, lo_q, lo_d;
  logic          done_q, done_d;
  logic          acc_en, op_en, cnt_en, res_en, done_en;

  logic [W:0]    part_next;
  logic          qbit;
  logic [W-1:0]  q_fin, r_fin;

  rdiv_step #(.W(W)) u_step (
    .part_in  (acc_q[AW-1:W]),
    .dvs      (dvs_q),
    .part_out (part_next),
    .qbit     (qbit)
  );

  rdiv_resign #(.W(W)) u_resign (
    .q_mag (acc_q[W-1:0]),
    .r_mag (acc_q[AW-1:W+1]),
    .q_neg (qneg_q),
    .r_neg (rneg_q),
    .q_out (q_fin),
    .r_out (r_fin)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    acc_d   = acc_q;
    dvs_d   = dvs_q;
    qneg_d  = qneg_q;
    rneg_d  = rneg_q;
    cnt_d   = cnt_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    done_d  = done_q;
    acc_en  = 1'b0;
    op_en   = 1'b0;
    cnt_en  = 1'b0;
    res_en  = 1'b0;
    done_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          acc_en  = 1'b1;
          op_en   = 1'b1;
          cnt_en  = 1'b1;
          done_en = 1'b1;
          acc_d   = {{(W+1){1'b0}}, op_mag[0]};
          dvs_d   = op_mag[1];
          qneg_d  = op_neg[0] ^ op_neg[1];
          rneg_d  = op_neg[0];
          cnt_d   = '0;
          done_d  = 1'b0;
          st_d    = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        acc_en = 1'b1;
        acc_d  = {acc_q[AW-2:0], 1'b0};
        st_d   = ST_STEP;
      end
      ST_STEP: begin
        acc_en = 1'b1;
        cnt_en = 1'b1;
        acc_d  = {part_next[W-1:0], acc_q[W-1:0], qbit};
        cnt_d  = cnt_q + CW'(1);
        if (cnt_q == CW'(W - 1)) st_d = ST_FIX;
      end
      ST_FIX: begin
        res_en  = 1'b1;
        done_en = 1'b1;
        hi_d    = r_fin;
        lo_d    = q_fin;
        done_d  = 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      acc_q  <= '0;
      dvs_q  <= '0;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
      cnt_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (acc_en) acc_q <= acc_d;
      if (op_en) begin
        dvs_q  <= dvs_d;
        qneg_q <= qneg_d;
        rneg_q <= rneg_d;
      end
      if (cnt_en) cnt_q <= cnt_d;
      if (res_en) begin
        hi_q <= hi_d;
        lo_q <= lo_d;
      end
      if (done_en) done_q <= done_d;
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign done = done_q;
  assign hi   = hi_q;
  assign lo   = lo_q;
endmodule

// File: rtl/rdiv_checker.sv
module rdiv_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         signed_mode,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  localparam int LW = $clog2(W + 3) + 1;

  logic [W-1:0]  cap_div;
  logic          cap_mode;
  logic [LW-1:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_div  <= '0;
      cap_mode <= 1'b0;
      lat      <= '0;
    end else if (start && !busy) begin
      cap_div  <= divisor;
      cap_mode <= signed_mode;
      lat      <= '0;
    end else if (busy) begin
      lat <= lat + LW'(1);
    end
  end

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (lat == LW'(W + 2)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(hi) && $stable(lo)));

  p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !cap_mode && (cap_div != '0)) |-> (hi < cap_div));

  p_divzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !cap_mode && (cap_div == '0)) |-> (lo == '1));
endmodule

bind rdiv_top rdiv_checker #(.W(W)) u_rdiv_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .signed_mode (signed_mode),
  .divisor     (divisor),
  .busy        (busy),
  .done        (done),
  .hi          (hi),
  .lo          (lo)
);

// File: tb/tb_rdiv_top.sv
module tb_rdiv_top;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic         signed_mode;
  logic [W-1:0] dividend;
  logic [W-1:0] divisor;
  logic         busy;
  logic         done;
  logic [W-1:0] hi;
  logic [W-1:0] lo;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  rdiv_top #(.W(W)) dut (
    .clk (clk), .rst_n (rst_n), .start (start), .signed_mode (signed_mode),
    .dividend (dividend), .divisor (divisor), .busy (busy), .done (done),
    .hi (hi), .lo (lo)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mag_of(input int v, input bit s);
    if (s && v[W-1]) return (M - v) % M;
    return v;
  endfunction

  // expected quotient / remainder from magnitudes and signs
  task automatic model(input int a, input int b, input bit s, output int q, output int r);
    int am, bm, qm, rm;
    bit an, bn;
    an = s && a[W-1];
    bn = s && b[W-1];
    am = mag_of(a, s);
    bm = mag_of(b, s);
    qm = (bm == 0) ? (M - 1) : (am / bm);
    rm = (bm == 0) ? am : (am % bm);
    q  = (an != bn) ? ((M - qm) % M) : qm;
    r  = an ? ((M - rm) % M) : rm;
  endtask

  task automatic launch(input int a, input int b, input bit s);
    @(negedge clk);
    dividend    = W'(a);
    divisor     = W'(b);
    signed_mode = s;
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    start       = 1'b0;
    signed_mode = 1'b0;
    dividend    = '0;
    divisor     = '0;
    rst_n       = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: after release, no start yet
    check("R1 hi", int'(hi), 0);
    check("R1 lo", int'(lo), 0);
    check("R1 busy after release", int'(busy), 0);

    begin
      int cyc;
      // R3: 7 / 2
      launch(7, 2, 1'b0);
      check("R7 busy after start", int'(busy), 1);
      wait_done(cyc);
      check("R3 quotient", int'(lo), 3);
      check("R3 remainder", int'(hi), 1);
      check("R7 latency", cyc, W + 2);
      check("R7 busy low at done", int'(busy), 0);

      // R8: outputs hold while done, whatever the inputs do
      dividend = 4'd15;
      divisor  = 4'd1;
      signed_mode = 1'b1;
      repeat (4) @(negedge clk);
      check("R8 hold lo", int'(lo), 3);
      check("R8 hold hi", int'(hi), 1);
      check("R8 done held", int'(done), 1);

      // R8: start during busy is ignored
      launch(13, 3, 1'b0);
      @(negedge clk);
      @(negedge clk);
      dividend    = 4'd2;
      divisor     = 4'd1;
      signed_mode = 1'b1;
      start       = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(cyc);
      check("R8 ignored start lo", int'(lo), 4);
      check("R8 ignored start hi", int'(hi), 1);
      repeat (2) @(negedge clk);
      check("R8 no second run", int'(busy), 0);
    end

    // exhaustive sweep, both modes
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < M; a++) begin
        for (int b = 0; b < M; b++) begin
          int q, r, cyc;
          string tq, tr;
          model(a, b, s[0], q, r);
          launch(a, b, s[0]);
          wait_done(cyc);
          if (b == 0) begin
            tq = "R6 quotient"; tr = "R6 remainder";
          end else if (s == 0) begin
            tq = "R2 quotient"; tr = "R2 remainder";
          end else begin
            tq = "R4 quotient"; tr = "R5 remainder";
          end
          check(tq, int'(lo), q);
          check(tr, int'(hi), r);
          check("R7 latency", cyc, W + 2);
        end
      end
    end

    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule